// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test port for a chip. Five signals make up its interface: a test clock, a mode-select line, serial data in, serial data out and an optional asynchronous reset. The mode-select line is sampled on each rising test clock and drives the standard sixteen-state test-port state machine. That machine moves scan data through a 10-bit instruction register or through one of four data registers. The data registers are a 1-bit bypass stage, a 32-bit identification word, a 32-bit user word and a boundary register whose length is a parameter.

The active instruction sets the controls that face the core. These are an output override that drives pins from the boundary register's update stage, a tri-state request for all pins, a clamp indication, and a single-cycle strobe that asks the core to reconfigure without touching the external reconfiguration pin. A new instruction takes effect only at the update step of an instruction scan. Test-Logic-Reset always returns the controller to the identification instruction.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The state machine follows the standard sixteen-state test-port graph on rising test clocks. Five consecutive clocks with mode-select high reach Test-Logic-Reset from any state, and Test-Logic-Reset makes the identification instruction (00_0000_0110) active.
- R2: While `trst_n` is low the controller is held in Test-Logic-Reset. The identification instruction is then active, every core control is low, `tdo_oe` is low and the boundary update stage is all zeros.
- R3: Capture-IR loads 00_0000_0001 into the instruction shift stage. Instruction bits shift in and out least significant bit first.
- R4: A newly shifted instruction changes no control until the Update-IR step. Before that step the previous instruction's controls stay in force.
- R5: BYPASS (11_1111_1111) and every opcode not listed in R6 to R11 select the 1-bit bypass stage. That stage captures 0 and delays scan data by exactly one clock.
- R6: IDCODE (00_0000_0110) shifts out `IDCODE_VAL` and USERCODE (00_0000_0111) shifts out `USERCODE_VAL`. Each word is 32 bits and goes out least significant bit first.
- R7: SAMPLE/PRELOAD (00_0000_0101) selects the boundary register. Capture-DR loads `pin_in` (bit 0 leaves first) and Update-DR copies the shifted pattern to `pin_out`. `pin_drive_en` stays low.
- R8: EXTEST (00_0000_1111) raises `pin_drive_en` with `pin_out` showing the update stage. It uses the same capture and update as R7.
- R9: HIGHZ (00_0000_1011) raises `pin_hiz` and selects the bypass stage. `pin_drive_en` stays low.
- R10: CLAMP (00_0000_1010) raises `pin_clamp` and `pin_drive_en` and selects the bypass stage. `pin_out` keeps the last updated boundary pattern.
- R11: With the reconfiguration opcode (00_0000_0001) active, every entry into Run-Test/Idle gives `reconfig_pulse` high for exactly one clock.
- R12: `pin_drive_en`, `pin_hiz` and `pin_clamp` keep their values until another instruction is updated or the controller passes through Test-Logic-Reset.
- R13: `tdo` and `tdo_oe` change only on falling test-clock edges. `tdo_oe` is high exactly in Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial scan data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial scan data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`, high in shift states |
| pin_in | input | BSR_LEN | Pin values captured into the boundary register |
| pin_out | output | BSR_LEN | Boundary update stage values for pins |
| pin_drive_en | output | 1 | Core pins take their values from `pin_out` |
| pin_hiz | output | 1 | Request to tri-state all pins |
| pin_clamp | output | 1 | Clamp instruction active |
| reconfig_pulse | output | 1 | One-clock reconfiguration request |

## Verification
Serial output is due one falling edge after the state machine enters a shift state. The bench therefore samples `tdo` and `tdo_oe` just after each falling edge and checks that `tdo` is unchanged just after the following rising edge. Core controls, `pin_out` and `reconfig_pulse` change on the rising edge that leaves Update-IR, Update-DR, Test-Logic-Reset or the state before Run-Test/Idle, so they are compared a few nanoseconds after every rising edge. A behavioural model advanced once per clock supplies the expected value for every one of those samples. Directed checks cover instruction timing, the bypass delay, the captured words and the clamp and tri-state cases.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
   localparam int IR_W = 10;
   localparam int ID_W = 32;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DR_SEL, ST_DR_CAP, ST_DR_SH, ST_DR_EX1, ST_DR_PA, ST_DR_EX2, ST_DR_UPD,
      ST_IR_SEL, ST_IR_CAP, ST_IR_SH, ST_IR_EX1, ST_IR_PA, ST_IR_EX2, ST_IR_UPD
   } tap_state_e;

   typedef enum logic [1:0] {SEL_BYP, SEL_IDC, SEL_USR, SEL_BND} dr_sel_e;

   localparam logic [IR_W-1:0] OP_SAMPLE  = 10'b00_0000_0101;
   localparam logic [IR_W-1:0] OP_EXTEST  = 10'b00_0000_1111;
   localparam logic [IR_W-1:0] OP_BYPASS  = 10'b11_1111_1111;
   localparam logic [IR_W-1:0] OP_USER    = 10'b00_0000_0111;
   localparam logic [IR_W-1:0] OP_IDENT   = 10'b00_0000_0110;
   localparam logic [IR_W-1:0] OP_HIGHZ   = 10'b00_0000_1011;
   localparam logic [IR_W-1:0] OP_CLAMP   = 10'b00_0000_1010;
   localparam logic [IR_W-1:0] OP_RECONF  = 10'b00_0000_0001;
   localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};
endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state,
   output tap_state_e state_nxt
);
   always_comb begin
      case (state)
         ST_RESET:  state_nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   state_nxt = tms ? ST_DR_SEL : ST_IDLE;
         ST_DR_SEL: state_nxt = tms ? ST_IR_SEL : ST_DR_CAP;
         ST_DR_CAP: state_nxt = tms ? ST_DR_EX1 : ST_DR_SH;
         ST_DR_SH:  state_nxt = tms ? ST_DR_EX1 : ST_DR_SH;
         ST_DR_EX1: state_nxt = tms ? ST_DR_UPD : ST_DR_PA;
         ST_DR_PA:  state_nxt = tms ? ST_DR_EX2 : ST_DR_PA;
         ST_DR_EX2: state_nxt = tms ? ST_DR_UPD : ST_DR_SH;
         ST_DR_UPD: state_nxt = tms ? ST_DR_SEL : ST_IDLE;
         ST_IR_SEL: state_nxt = tms ? ST_RESET  : ST_IR_CAP;
         ST_IR_CAP: state_nxt = tms ? ST_IR_EX1 : ST_IR_SH;
         ST_IR_SH:  state_nxt = tms ? ST_IR_EX1 : ST_IR_SH;
         ST_IR_EX1: state_nxt = tms ? ST_IR_UPD : ST_IR_PA;
         ST_IR_PA:  state_nxt = tms ? ST_IR_EX2 : ST_IR_PA;
         ST_IR_EX2: state_nxt = tms ? ST_IR_UPD : ST_IR_SH;
         default:   state_nxt = tms ? ST_DR_SEL : ST_IDLE;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= ST_RESET;
      else        state <= state_nxt;
   end
endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
   import scan_tap_pkg::*;
#(
   parameter logic [IR_W-1:0] RESET_OP = OP_IDENT
)(
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic            ir_so,
   output logic [IR_W-1:0] ir_q,
   output logic [IR_W-1:0] ir_next
);
   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sr <= IR_CAPTURE;
         ir_q  <= RESET_OP;
      end else begin
         if (state == ST_IR_CAP)     ir_sr <= IR_CAPTURE;
         else if (state == ST_IR_SH) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
         ir_q <= ir_next;
      end
   end

   always_comb begin
      if (state == ST_IR_UPD)     ir_next = ir_sr;
      else if (state == ST_RESET) ir_next = RESET_OP;
      else                        ir_next = ir_q;
   end

   assign ir_so = ir_sr[0];
endmodule

// File: rtl/scan_tap_decode.sv
module scan_tap_decode
   import scan_tap_pkg::*;
(
   input  logic [IR_W-1:0] ir,
   output dr_sel_e         dr_sel,
   output logic            hiz,
   output logic            clamp,
   output logic            drive_en
);
   always_comb begin
      dr_sel   = SEL_BYP;
      hiz      = 1'b0;
      clamp    = 1'b0;
      drive_en = 1'b0;
      case (ir)
         OP_SAMPLE: dr_sel = SEL_BND;
         OP_EXTEST: begin dr_sel = SEL_BND; drive_en = 1'b1; end
         OP_IDENT:  dr_sel = SEL_IDC;
         OP_USER:   dr_sel = SEL_USR;
         OP_HIGHZ:  hiz = 1'b1;
         OP_CLAMP:  begin clamp = 1'b1; drive_en = 1'b1; end
         default:   dr_sel = SEL_BYP;
      endcase
   end
endmodule

// File: rtl/scan_tap_const_dr.sv
module scan_tap_const_dr #(
   parameter int           W   = 32,
   parameter logic [W-1:0] VAL = '0
)(
   input  logic tck,
   input  logic rst_n,
   input  logic tdi,
   input  logic capture,
   input  logic shift,
   output logic so
);
   logic [W-1:0] sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       sr <= VAL;
      else if (capture) sr <= VAL;
      else if (shift)   sr <= {tdi, sr[W-1:1]};
   end

   assign so = sr[0];
endmodule

// File: rtl/scan_tap_bsr.sv
module scan_tap_bsr #(
   parameter int LEN = 8
)(
   input  logic           tck,
   input  logic           rst_n,
   input  logic           tdi,
   input  logic           capture,
   input  logic           shift,
   input  logic           update,
   input  logic [LEN-1:0] pin_in,
   output logic           so,
   output logic [LEN-1:0] upd_q
);
   logic [LEN-1:0] sr;

   generate
      if (LEN == 1) begin : g_one
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)       sr <= '0;
            else if (capture) sr <= pin_in;
            else if (shift)   sr <= tdi;
         end
      end else begin : g_many
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)       sr <= '0;
            else if (capture) sr <= pin_in;
            else if (shift)   sr <= {tdi, sr[LEN-1:1]};
         end
      end
   endgenerate

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      upd_q <= '0;
      else if (update) upd_q <= sr;
   end

   assign so = sr[0];
endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
   import scan_tap_pkg::*;
#(
   parameter int          BSR_LEN      = 8,
   parameter logic [31:0] IDCODE_VAL   = 32'h2A5C_10DD,
   parameter logic [31:0] USERCODE_VAL = 32'hC0DE_F00D,
   parameter bit          USE_TRST     = 1'b1
)(
   input  logic               tck,
   input  logic               tms,
   input  logic               tdi,
   input  logic               trst_n,
   output logic               tdo,
   output logic               tdo_oe,
   input  logic [BSR_LEN-1:0] pin_in,
   output logic [BSR_LEN-1:0] pin_out,
   output logic               pin_drive_en,
   output logic               pin_hiz,
   output logic               pin_clamp,
   output logic               reconfig_pulse
);
   localparam int N_CONST = 2;

   generate
      if (BSR_LEN < 1) begin : g_bad_len
         $error("BSR_LEN must be at least 1");
      end
      if (IDCODE_VAL[0] != 1'b1) begin : g_bad_id
         $error("IDCODE_VAL bit 0 must be 1");
      end
   endgenerate

   logic rst_n;
   generate
      if (USE_TRST) begin : g_trst
         assign rst_n = trst_n;
      end else begin : g_no_trst
         assign rst_n = 1'b1;
      end
   endgenerate

   tap_state_e      state, state_nxt;
   logic [IR_W-1:0] ir_q, ir_next;
   logic            ir_so, bnd_so, byp_q, shift_out;
   dr_sel_e         dr_sel;
   logic [N_CONST-1:0] cdr_so, cdr_hit;
   logic [31:0]     cdr_val [N_CONST];
   logic            dr_cap, dr_sh, dr_upd;

   assign dr_cap = (state == ST_DR_CAP);
   assign dr_sh  = (state == ST_DR_SH);
   assign dr_upd = (state == ST_DR_UPD);

   scan_tap_fsm u_fsm (
      .tck(tck), .rst_n(rst_n), .tms(tms), .state(state), .state_nxt(state_nxt)
   );

   scan_tap_ir #(.RESET_OP(OP_IDENT)) u_ir (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
      .ir_so(ir_so), .ir_q(ir_q), .ir_next(ir_next)
   );

   scan_tap_decode u_dec (
      .ir(ir_q), .dr_sel(dr_sel), .hiz(pin_hiz), .clamp(pin_clamp),
      .drive_en(pin_drive_en)
   );

   assign cdr_hit    = {dr_sel == SEL_USR, dr_sel == SEL_IDC};
   assign cdr_val[0] = IDCODE_VAL;
   assign cdr_val[1] = USERCODE_VAL;

   genvar g;
   generate
      for (g = 0; g < N_CONST; g++) begin : g_cdr
         scan_tap_const_dr #(
            .W(ID_W), .VAL((g == 0) ? IDCODE_VAL : USERCODE_VAL)
         ) u_cdr (
            .tck(tck), .rst_n(rst_n), .tdi(tdi),
            .capture(dr_cap && cdr_hit[g]), .shift(dr_sh && cdr_hit[g]),
            .so(cdr_so[g])
         );
      end
   endgenerate

   scan_tap_bsr #(.LEN(BSR_LEN)) u_bsr (
      .tck(tck), .rst_n(rst_n), .tdi(tdi),
      .capture(dr_cap && dr_sel == SEL_BND),
      .shift(dr_sh && dr_sel == SEL_BND),
      .update(dr_upd && dr_sel == SEL_BND),
      .pin_in(pin_in), .so(bnd_so), .upd_q(pin_out)
   );

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                            byp_q <= 1'b0;
      else if (dr_cap && dr_sel == SEL_BYP)  byp_q <= 1'b0;
      else if (dr_sh && dr_sel == SEL_BYP)   byp_q <= tdi;
   end

   always_comb begin
      if (state == ST_IR_SH) shift_out = ir_so;
      else begin
         case (dr_sel)
            SEL_IDC: shift_out = cdr_so[0];
            SEL_USR: shift_out = cdr_so[1];
            SEL_BND: shift_out = bnd_so;
            default: shift_out = byp_q;
         endcase
      end
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= shift_out;
         tdo_oe <= (state == ST_DR_SH) || (state == ST_IR_SH);
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) reconfig_pulse <= 1'b0;
      else        reconfig_pulse <= (state != ST_IDLE) && (state_nxt == ST_IDLE)
                                    && (ir_next == OP_RECONF);
   end

   logic unused_cdr;
   assign unused_cdr = ^{cdr_val[0], cdr_val[1]};
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
   import scan_tap_pkg::*;
(
   input logic            tck,
   input logic            trst_n,
   input tap_state_e      state,
   input logic [IR_W-1:0] ir_q,
   input logic            tdo_oe,
   input logic            pin_hiz,
   input logic            pin_clamp,
   input logic            pin_drive_en,
   input logic            reconfig_pulse
);
   AST_RESET_IDENT: assert property (@(posedge tck) disable iff (!trst_n)
      state == ST_RESET |=> ir_q == OP_IDENT); // R1

   AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (state == ST_DR_SH || state == ST_IR_SH)); // R13

   AST_HIZ_NO_DRIVE: assert property (@(posedge tck) disable iff (!trst_n)
      pin_hiz |-> !pin_drive_en); // R9

   AST_CLAMP_DRIVES: assert property (@(posedge tck) disable iff (!trst_n)
      pin_clamp |-> pin_drive_en && !pin_hiz); // R10

   AST_PULSE_SINGLE: assert property (@(posedge tck) disable iff (!trst_n)
      reconfig_pulse |=> !reconfig_pulse); // R11

   AST_PULSE_IN_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
      reconfig_pulse |-> state == ST_IDLE); // R11

   AST_CTRL_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_IR_UPD && state != ST_RESET)
      |=> $stable({pin_hiz, pin_clamp, pin_drive_en})); // R12
endmodule

bind scan_tap_ctrl scan_tap_chk i_scan_tap_chk (
   .tck(tck), .trst_n(trst_n), .state(state), .ir_q(ir_q), .tdo_oe(tdo_oe),
   .pin_hiz(pin_hiz), .pin_clamp(pin_clamp), .pin_drive_en(pin_drive_en),
   .reconfig_pulse(reconfig_pulse)
);

// File: tb/test_scan_tap_ctrl.sv
module test_scan_tap_ctrl;
   localparam int          NB  = 8;
   localparam logic [31:0] IDV = 32'h2A5C_10DD;
   localparam logic [31:0] USV = 32'hC0DE_F00D;

   localparam logic [9:0] C_SAMPLE = 10'b0000000101, C_EXTEST = 10'b0000001111,
                          C_BYPASS = 10'b1111111111, C_USER = 10'b0000000111,
                          C_IDENT = 10'b0000000110, C_HIGHZ = 10'b0000001011,
                          C_CLAMP = 10'b0000001010, C_RECONF = 10'b0000000001;

   // model states: 0 reset, 1 idle, 2..8 DR path, 9..15 IR path
   localparam int M_RST = 0, M_IDLE = 1, M_DSEL = 2, M_DCAP = 3, M_DSH = 4,
                  M_DEX1 = 5, M_DPA = 6, M_DEX2 = 7, M_DUPD = 8, M_ISEL = 9,
                  M_ICAP = 10, M_ISH = 11, M_IEX1 = 12, M_IPA = 13, M_IEX2 = 14,
                  M_IUPD = 15;

   logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
   logic tdo, tdo_oe, pin_drive_en, pin_hiz, pin_clamp, reconfig_pulse;
   logic [NB-1:0] pin_in = '0, pin_out;

   int checks = 0, errors = 0, pulses = 0;
   bit done = 0;

   int        m_st;
   logic [9:0] m_ir, m_irsh;
   bit        dq[$];
   logic [NB-1:0] m_upd;

   scan_tap_ctrl #(.BSR_LEN(NB), .IDCODE_VAL(IDV), .USERCODE_VAL(USV)) i_scan_tap_ctrl (
      .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo), .tdo_oe(tdo_oe),
      .pin_in(pin_in), .pin_out(pin_out), .pin_drive_en(pin_drive_en),
      .pin_hiz(pin_hiz), .pin_clamp(pin_clamp), .reconfig_pulse(reconfig_pulse)
   );

   always #10 tck = ~tck;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int m_next(input int s, input bit t);
      case (s)
         M_RST:  return t ? M_RST  : M_IDLE;
         M_IDLE: return t ? M_DSEL : M_IDLE;
         M_DSEL: return t ? M_ISEL : M_DCAP;
         M_DCAP, M_DSH: return t ? M_DEX1 : M_DSH;
         M_DEX1: return t ? M_DUPD : M_DPA;
         M_DPA:  return t ? M_DEX2 : M_DPA;
         M_DEX2: return t ? M_DUPD : M_DSH;
         M_ISEL: return t ? M_RST  : M_ICAP;
         M_ICAP, M_ISH: return t ? M_IEX1 : M_ISH;
         M_IEX1: return t ? M_IUPD : M_IPA;
         M_IPA:  return t ? M_IEX2 : M_IPA;
         M_IEX2: return t ? M_IUPD : M_ISH;
         default: return t ? M_DSEL : M_IDLE;
      endcase
   endfunction

   function automatic int m_sel();   // 0 bypass, 1 id, 2 user, 3 boundary
      if (m_ir == C_SAMPLE || m_ir == C_EXTEST) return 3;
      if (m_ir == C_IDENT) return 1;
      if (m_ir == C_USER) return 2;
      return 0;
   endfunction

   function automatic string dr_req();
      case (m_sel())
         0: return "R5";
         3: return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic m_reset();
      m_st = M_RST; m_ir = C_IDENT; m_irsh = 10'd1; m_upd = '0; dq.delete();
   endtask

   task automatic step(input bit tv, input bit dv, output bit so);
      int nx;
      bit pre;
      bit exp_p;
      @(negedge tck); #2;
      tms = tv; tdi = dv;
      so = tdo; pre = tdo;
      chk(tdo_oe == (m_st == M_DSH || m_st == M_ISH), "R13", "tdo_oe", tdo_oe,
          (m_st == M_DSH || m_st == M_ISH));
      if (m_st == M_ISH) chk(tdo == m_irsh[0], "R3", "ir tdo", tdo, m_irsh[0]);
      if (m_st == M_DSH) chk(tdo == dq[0], dr_req(), "dr tdo", tdo, dq[0]);
      @(posedge tck);
      nx = m_next(m_st, tv);
      case (m_st)
         M_RST:  m_ir = C_IDENT;
         M_ICAP: m_irsh = 10'd1;
         M_ISH:  m_irsh = {dv, m_irsh[9:1]};
         M_IUPD: m_ir = m_irsh;
         M_DCAP: begin
            dq.delete();
            case (m_sel())
               1: for (int i = 0; i < 32; i++) dq.push_back(IDV[i]);
               2: for (int i = 0; i < 32; i++) dq.push_back(USV[i]);
               3: for (int i = 0; i < NB; i++) dq.push_back(pin_in[i]);
               default: dq.push_back(1'b0);
            endcase
         end
         M_DSH: begin void'(dq.pop_front()); dq.push_back(dv); end
         M_DUPD: if (m_sel() == 3) for (int i = 0; i < NB; i++) m_upd[i] = dq[i];
         default: ;
      endcase
      exp_p = (m_st != M_IDLE) && (nx == M_IDLE) && (m_ir == C_RECONF);
      m_st = nx;
      #2;
      chk(tdo == pre, "R13", "tdo moved at rising edge", tdo, pre);
      chk(pin_hiz == (m_ir == C_HIGHZ), "R9", "pin_hiz", pin_hiz, m_ir == C_HIGHZ);
      chk(pin_clamp == (m_ir == C_CLAMP), "R10", "pin_clamp", pin_clamp, m_ir == C_CLAMP);
      chk(pin_drive_en == (m_ir == C_EXTEST || m_ir == C_CLAMP), "R8", "pin_drive_en",
          pin_drive_en, (m_ir == C_EXTEST || m_ir == C_CLAMP));
      chk(pin_out == m_upd, "R7", "pin_out", pin_out, m_upd);
      chk(reconfig_pulse == exp_p, "R11", "reconfig_pulse", reconfig_pulse, exp_p);
      if (reconfig_pulse) pulses++;
   endtask

   task automatic to_idle();
      bit s;
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, s);
      step(1'b0, 1'b0, s);
   endtask

   task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
      bit s;
      step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
      for (int i = 0; i < 10; i++) begin step(i == 9, op[i], s); cap[i] = s; end
      step(1, 0, s); step(0, 0, s);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      bit s;
      dout = '0;
      step(1, 0, s); step(0, 0, s); step(0, 0, s);
      for (int i = 0; i < n; i++) begin step(i == n - 1, din[i], s); dout[i] = s; end
      step(1, 0, s); step(0, 0, s);
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [9:0] cap;
      logic [63:0] dout;
      bit s;
      m_reset();
      #35;
      chk(!pin_hiz && !pin_clamp && !pin_drive_en && !reconfig_pulse && !tdo_oe,
          "R2", "controls in reset", {pin_hiz, pin_clamp, pin_drive_en, tdo_oe}, 0);
      trst_n = 1'b1;
      to_idle();

      // R1 / R6: default instruction reads the identification word
      scan_dr(32, 64'h0, dout);
      chk(dout[31:0] == IDV, "R1", "idcode after reset", dout[31:0], IDV);

      // R3: capture pattern and R6 user word
      load_ir(C_USER, cap);
      chk(cap == 10'd1, "R3", "ir capture", cap, 10'd1);
      scan_dr(32, 64'h0, dout);
      chk(dout[31:0] == USV, "R6", "usercode", dout[31:0], USV);

      // R5: bypass delay of one clock
      load_ir(C_BYPASS, cap);
      scan_dr(9, 64'h0B5, dout);
      chk(dout[8:0] == {8'hB5, 1'b0}, "R5", "bypass delay", dout[8:0], {8'hB5, 1'b0});
      load_ir(10'h155, cap);
      scan_dr(5, 64'h0D, dout);
      chk(dout[4:0] == 5'b11010, "R5", "undefined opcode bypass", dout[4:0], 5'b11010);

      // R7: sample / preload
      pin_in = 8'hA5;
      load_ir(C_SAMPLE, cap);
      scan_dr(NB, 64'h3C, dout);
      chk(dout[NB-1:0] == 8'hA5, "R7", "sample capture", dout[NB-1:0], 8'hA5);
      chk(pin_out == 8'h3C && !pin_drive_en, "R7", "preload", pin_out, 8'h3C);

      // R8: external test
      load_ir(C_EXTEST, cap);
      chk(pin_drive_en && pin_out == 8'h3C, "R8", "extest drive", pin_out, 8'h3C);
      pin_in = 8'h5E;
      scan_dr(NB, 64'h3C, dout);
      chk(dout[NB-1:0] == 8'h5E, "R8", "extest capture", dout[NB-1:0], 8'h5E);

      // R10 clamp, then R4 pending instruction has no effect before update
      load_ir(C_CLAMP, cap);
      chk(pin_clamp && pin_drive_en && pin_out == 8'h3C, "R10", "clamp", pin_out, 8'h3C);
      scan_dr(3, 64'h5, dout);
      chk(dout[2:0] == 3'b010, "R10", "clamp bypass path", dout[2:0], 3'b010);
      chk(pin_clamp, "R12", "clamp held over scans", pin_clamp, 1);
      step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
      for (int i = 0; i < 10; i++) step(i == 9, C_HIGHZ[i], s);
      chk(pin_clamp && !pin_hiz, "R4", "before update", {pin_clamp, pin_hiz}, 2'b10);
      step(1, 0, s);
      chk(pin_clamp && !pin_hiz, "R4", "in update state", {pin_clamp, pin_hiz}, 2'b10);
      step(0, 0, s);
      chk(pin_hiz && !pin_clamp && !pin_drive_en, "R9", "highz", {pin_hiz, pin_drive_en}, 2'b10);
      scan_dr(3, 64'h6, dout);
      chk(dout[2:0] == 3'b100, "R9", "highz bypass path", dout[2:0], 3'b100);

      // R12: test-logic-reset clears controls
      to_idle();
      chk(!pin_hiz, "R12", "cleared by tms reset", pin_hiz, 0);

      // R11: reconfiguration strobe
      pulses = 0;
      load_ir(C_RECONF, cap);
      chk(pulses == 1, "R11", "pulse count after update", pulses, 1);
      scan_dr(2, 64'h0, dout);
      chk(pulses == 2, "R11", "pulse on re-entry", pulses, 2);

      // R2: asynchronous reset during external test
      load_ir(C_EXTEST, cap);
      #3 trst_n = 1'b0;
      #2;
      m_reset();
      chk(!pin_drive_en && pin_out == '0, "R2", "async reset", {pin_drive_en, pin_out}, 0);
      #3 trst_n = 1'b1;
      step(0, 0, s);
      scan_dr(32, 64'h0, dout);
      chk(dout[31:0] == IDV, "R2", "ident after trst", dout[31:0], IDV);

      // R1: five high clocks from inside a data shift
      load_ir(C_USER, cap);
      step(1, 0, s); step(0, 0, s); step(0, 0, s); step(0, 0, s);
      to_idle();
      scan_dr(32, 64'h0, dout);
      chk(dout[31:0] == IDV, "R1", "ident after tms reset", dout[31:0], IDV);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule